// File: doc/BRIEF.md
# Reference Bank Rotation Controller

This controller sits in front of four single-port reference-pixel banks that feed an integer motion search engine. Each bank holds one vertical slice of a search window. The search engine always reads two banks at once, so a window is spread over three banks and the third bank can be refilled from external memory while the other two are searched.

For every macroblock the controller receives the coarse motion vector carried over from the source stream. It compares this vector with the previous one. When the two are close, the window slides one macroblock to the right. The controller then keeps two of the banks and refills only the one that comes next in a circular rotation of banks 0, 1 and 2. When the vectors jump, the window is rebuilt. The spare bank 3 is refilled together with the bank that follows it, and for the next macroblock the search reads bank 3 in place of a stale bank.

The schedule has nine states, each lasting one full search pass. Every refill is issued at the first clock of a state and completes well inside that state, so the search engine never waits. Bank 3 may be powered down whenever the current state neither reads nor writes it.

Top module: `bankRotTop`

## Requirements
- R1: After reset the controller is in a fill-only phase. It holds fill requests for banks 3 and 1 (fillReq = 4'b1010) and drives bankWe = 4'b1010 for the first FILL_CYCLES clocks. It issues no meStart. It leaves this phase at the first clock where the count has reached FILL_CYCLES and both fills are done. The next clock starts the first search state, which reads bank 3 first and bank 1 second. The vector present on the last clock of this phase is taken as non-smooth.
- R2: A vector is sampled on the last clock of the fill-only phase and on the last clock of every state that is followed by a decision state. The step is smooth when both |mvX - previous mvX| and |mvY - previous mvY| are below SMOOTH_THRESH (6). The result selects the refills and the successor of the decision state that begins on the next clock.
- R3: Bank numbers on rdBankA/rdBankB are plain binary 0..3, with A the first bank read. On smooth decisions the sequence runs S01, S01r, S12, S12r, S20, S20r, S01, and so on. The reads are (0,1), (0,1), (1,2), (1,2), (2,0), (2,0). A smooth decision state refills nothing. The reuse states S01r, S12r and S20r refill banks 2, 0 and 1 respectively.
- R4: On a non-smooth decision, S01 goes to S32 and then S20. S12 goes to S30 and then S01. S20 goes to S31 and then S12. The decision state refills bank 3 plus the second bank of the bank-3 state that follows (S01: 3 and 2; S12: 3 and 0; S20: 3 and 1). S32, S30 and S31 read (3,2), (3,0) and (3,1), and refill banks 0, 1 and 2 respectively.
- R5: Every search state lasts exactly SEARCH_CYCLES clocks. meStart is high only in its first clock.
- R6: At the first clock of a state, fillReq shows that state's refill mask. A bit stays high until a fillDone pulse arrives for that bank. bankWe equals the mask during the first FILL_CYCLES clocks of the state and is zero afterwards.
- R7: No bank is refilled in a state that reads it.
- R8: bank3Sleep is high exactly when the current state neither reads bank 3 nor refills it.
- R9: winX/winY hold the search window origin. On a smooth sample the origin moves +WIN_STEP (16) in x and keeps y. On a non-smooth sample, and at the end of the fill-only phase, it is loaded with the sign-extended sampled vector. It does not change otherwise.
- R10: If any requested refill has not received fillDone by the last clock of its state, fillErr becomes 1 on the next clock and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mvX | input | MV_W | Coarse motion vector, x component (signed) |
| mvY | input | MV_W | Coarse motion vector, y component (signed) |
| fillDone | input | 4 | One-clock pulse per bank when its refill has completed |
| rdBankA | output | 2 | Bank read first by the search engine |
| rdBankB | output | 2 | Bank read second by the search engine |
| meStart | output | 1 | Start pulse to the search engine, first clock of each state |
| bankWe | output | 4 | Write enable per bank during a refill |
| fillReq | output | 4 | Outstanding refill request per bank |
| bank3Sleep | output | 1 | Spare bank may be powered down |
| winX | output | WIN_W | Search window origin, x (two's complement) |
| winY | output | WIN_W | Search window origin, y (two's complement) |
| fillErr | output | 1 | Sticky refill-overrun flag |

## Verification
Two things happen on the same clock edge. The vector is sampled and judged, and the refill set of the decision state that starts on that edge is chosen from that very judgement. If the decision were registered one clock late, the wrong bank would be written at the first clock of the state. The bench provokes this by sweeping every x/y step from -7 to +7, which covers both sides of the threshold and both signs. It judges the result at the first clock of each decision state, using fillReq, bankWe, the bank reads and the window origin, all computed from its own schedule model.

// File: rtl/bankRotPkg.sv
package bankRotPkg;

  typedef enum logic [3:0] {
    ST_INIT = 4'd0,
    ST_01   = 4'd1,
    ST_12   = 4'd2,
    ST_20   = 4'd3,
    ST_01R  = 4'd4,
    ST_12R  = 4'd5,
    ST_20R  = 4'd6,
    ST_31   = 4'd7,
    ST_32   = 4'd8,
    ST_30   = 4'd9
  } bankState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;  // take the vector on this clock
    logic flush;   // load origin unconditionally (start-up)
  } dpStrobe_t;

  function automatic bankState_t nextState(bankState_t s, logic smooth);
    case (s)
      ST_01:   return smooth ? ST_01R : ST_32;
      ST_12:   return smooth ? ST_12R : ST_30;
      ST_20:   return smooth ? ST_20R : ST_31;
      ST_01R:  return ST_12;
      ST_12R:  return ST_20;
      ST_20R:  return ST_01;
      ST_31:   return ST_12;
      ST_32:   return ST_20;
      ST_30:   return ST_01;
      default: return ST_31;
    endcase
  endfunction

  function automatic logic [3:0] refillMask(bankState_t s, logic smooth);
    case (s)
      ST_01:   return smooth ? 4'b0000 : 4'b1100;
      ST_12:   return smooth ? 4'b0000 : 4'b1001;
      ST_20:   return smooth ? 4'b0000 : 4'b1010;
      ST_01R:  return 4'b0100;
      ST_12R:  return 4'b0001;
      ST_20R:  return 4'b0010;
      ST_31:   return 4'b0100;
      ST_32:   return 4'b0001;
      ST_30:   return 4'b0010;
      default: return 4'b1010;
    endcase
  endfunction

  function automatic logic [1:0] readFirst(bankState_t s);
    case (s)
      ST_01, ST_01R: return 2'd0;
      ST_12, ST_12R: return 2'd1;
      ST_20, ST_20R: return 2'd2;
      default:       return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] readSecond(bankState_t s);
    case (s)
      ST_01, ST_01R, ST_31: return 2'd1;
      ST_12, ST_12R, ST_32: return 2'd2;
      ST_20, ST_20R, ST_30: return 2'd0;
      default:              return 2'd1;
    endcase
  endfunction

  function automatic logic isPreDecision(bankState_t s);
    case (s)
      ST_01R, ST_12R, ST_20R, ST_31, ST_32, ST_30: return 1'b1;
      default:                                     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bankRotDp.sv
module bankRotDp
  import bankRotPkg::*;
#(
  parameter int MV_W          = 10,
  parameter int WIN_W         = 12,
  parameter int SMOOTH_THRESH = 6,
  parameter int WIN_STEP      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [MV_W-1:0]  mvX,
  input  logic signed [MV_W-1:0]  mvY,
  input  dpStrobe_t               strb,
  output logic                    smooth,
  output logic [WIN_W-1:0]        winX,
  output logic [WIN_W-1:0]        winY
);

  localparam logic [MV_W:0]  THR  = (MV_W+1)'(SMOOTH_THRESH);
  localparam logic [WIN_W-1:0] STEP = WIN_W'(WIN_STEP);

  logic signed [MV_W-1:0] prevX, prevY;
  logic [MV_W:0] dX, dY, magX, magY;
  logic [WIN_W-1:0] extX, extY;

  always_comb begin
    dX   = {mvX[MV_W-1], mvX} - {prevX[MV_W-1], prevX};
    dY   = {mvY[MV_W-1], mvY} - {prevY[MV_W-1], prevY};
    magX = dX[MV_W] ? (~dX + 1'b1) : dX;
    magY = dY[MV_W] ? (~dY + 1'b1) : dY;
    smooth = (magX < THR) && (magY < THR);
    extX = {{(WIN_W-MV_W){mvX[MV_W-1]}}, mvX};
    extY = {{(WIN_W-MV_W){mvY[MV_W-1]}}, mvY};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevX <= '0;
      prevY <= '0;
      winX  <= '0;
      winY  <= '0;
    end else if (strb.sample) begin
      prevX <= mvX;
      prevY <= mvY;
      if (strb.flush || !smooth) begin
        winX <= extX;
        winY <= extY;
      end else begin
        winX <= winX + STEP;
      end
    end
  end

  // R9
  win_slide_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample && !strb.flush && smooth |=> (winX == $past(winX) + STEP) && (winY == $past(winY)));

  // R9
  win_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample && (strb.flush || !smooth) |=> (winX == $past(extX)) && (winY == $past(extY)));

  // R9
  win_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sample |=> $stable(winX) && $stable(winY));

endmodule

// File: rtl/bankRotCtrl.sv
module bankRotCtrl
  import bankRotPkg::*;
#(
  parameter int SEARCH_CYCLES = 527,
  parameter int FILL_CYCLES   = 47
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  fillDone,
  input  logic        smooth,
  output dpStrobe_t   strb,
  output logic [1:0]  rdBankA,
  output logic [1:0]  rdBankB,
  output logic        meStart,
  output logic [3:0]  bankWe,
  output logic [3:0]  fillReq,
  output logic        bank3Sleep,
  output logic        fillErr
);

  localparam int CNT_W = $clog2(SEARCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(SEARCH_CYCLES - 1);
  localparam logic [CNT_W-1:0] FILL_END = CNT_W'(FILL_CYCLES);

  bankState_t st, stNext;
  logic [CNT_W-1:0] cnt;
  logic [3:0] pend, fillMask, pendLeft, maskNext;
  logic smoothQ, inInit, lastCyc, initGo, advance;

  always_comb begin
    inInit   = (st == ST_INIT);
    pendLeft = pend & ~fillDone;
    lastCyc  = !inInit && (cnt == LAST);
    initGo   = inInit && (pend == 4'b0000) && (cnt == FILL_END);
    advance  = lastCyc || initGo;
    stNext   = inInit ? ST_31 : nextState(st, smoothQ);
    maskNext = refillMask(stNext, smooth);
    strb.sample = advance && (inInit || isPreDecision(st));
    strb.flush  = initGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_INIT;
      cnt      <= '0;
      pend     <= refillMask(ST_INIT, 1'b0);
      fillMask <= refillMask(ST_INIT, 1'b0);
      smoothQ  <= 1'b0;
      fillErr  <= 1'b0;
    end else begin
      if (lastCyc && (pendLeft != 4'b0000)) fillErr <= 1'b1;
      if (strb.sample) smoothQ <= smooth;
      if (advance) begin
        st       <= stNext;
        cnt      <= '0;
        pend     <= maskNext;
        fillMask <= maskNext;
      end else begin
        pend <= pendLeft;
        if (!(inInit && (cnt == FILL_END))) cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    rdBankA    = readFirst(st);
    rdBankB    = readSecond(st);
    meStart    = !inInit && (cnt == '0);
    bankWe     = (cnt < FILL_END) ? fillMask : 4'b0000;
    fillReq    = pend;
    bank3Sleep = !fillMask[3] && (rdBankA != 2'd3) && (rdBankB != 2'd3);
  end

  // R7
  rw_disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inInit |-> !fillMask[rdBankA] && !fillMask[rdBankB] && (rdBankA != rdBankB));

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    meStart |=> !meStart);

  // R6
  fill_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    meStart |-> (bankWe == fillReq));

  // R8
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    bank3Sleep |-> !bankWe[3] && !fillReq[3]);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillErr |=> fillErr);

endmodule

// File: rtl/bankRotTop.sv
module bankRotTop
  import bankRotPkg::*;
#(
  parameter int SEARCH_CYCLES = 527,
  parameter int FILL_CYCLES   = 47,
  parameter int MV_W          = 10,
  parameter int WIN_W         = 12,
  parameter int SMOOTH_THRESH = 6,
  parameter int WIN_STEP      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [MV_W-1:0]  mvX,
  input  logic signed [MV_W-1:0]  mvY,
  input  logic [3:0]              fillDone,
  output logic [1:0]              rdBankA,
  output logic [1:0]              rdBankB,
  output logic                    meStart,
  output logic [3:0]              bankWe,
  output logic [3:0]              fillReq,
  output logic                    bank3Sleep,
  output logic [WIN_W-1:0]        winX,
  output logic [WIN_W-1:0]        winY,
  output logic                    fillErr
);

  dpStrobe_t strb;
  logic smooth;

  bankRotCtrl #(
    .SEARCH_CYCLES(SEARCH_CYCLES),
    .FILL_CYCLES  (FILL_CYCLES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fillDone  (fillDone),
    .smooth    (smooth),
    .strb      (strb),
    .rdBankA   (rdBankA),
    .rdBankB   (rdBankB),
    .meStart   (meStart),
    .bankWe    (bankWe),
    .fillReq   (fillReq),
    .bank3Sleep(bank3Sleep),
    .fillErr   (fillErr)
  );

  bankRotDp #(
    .MV_W         (MV_W),
    .WIN_W        (WIN_W),
    .SMOOTH_THRESH(SMOOTH_THRESH),
    .WIN_STEP     (WIN_STEP)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .mvX   (mvX),
    .mvY   (mvY),
    .strb  (strb),
    .smooth(smooth),
    .winX  (winX),
    .winY  (winY)
  );

endmodule

// File: tb/test_bankRotTop.sv
`timescale 1ns/1ps
module test_bankRotTop;

  localparam int LEN  = 16;
  localparam int FILL = 4;
  localparam int MVW  = 10;
  localparam int WW   = 12;
  localparam int NVEC = 225;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [MVW-1:0] mvX = '0, mvY = '0;
  logic [3:0] fillDone = 4'b0;
  logic [1:0] rdBankA, rdBankB;
  logic meStart, bank3Sleep, fillErr;
  logic [3:0] bankWe, fillReq;
  logic [WW-1:0] winX, winY;

  always #10 clk = ~clk;  // 50 MHz

  bankRotTop #(.SEARCH_CYCLES(LEN), .FILL_CYCLES(FILL), .MV_W(MVW), .WIN_W(WW),
               .SMOOTH_THRESH(6), .WIN_STEP(16)) i_bankRotTop (
    .clk(clk), .rstN(rstN), .mvX(mvX), .mvY(mvY), .fillDone(fillDone),
    .rdBankA(rdBankA), .rdBankB(rdBankB), .meStart(meStart), .bankWe(bankWe),
    .fillReq(fillReq), .bank3Sleep(bank3Sleep), .winX(winX), .winY(winY), .fillErr(fillErr));

  int checks = 0, errors = 0;
  bit finished = 0;

  // model: 0 init,1 S01,2 S12,3 S20,4 S01r,5 S12r,6 S20r,7 S31,8 S32,9 S30
  int ms, mcs, vecIdx, curVX, curVY, prevMX, prevMY, winMX, winMY;
  bit errExp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mNext(int s, int sm);
    case (s)
      1: return sm ? 4 : 8;
      2: return sm ? 5 : 9;
      3: return sm ? 6 : 7;
      4: return 2; 5: return 3; 6: return 1;
      7: return 2; 8: return 3; 9: return 1;
      default: return 7;
    endcase
  endfunction

  function automatic logic [3:0] mMask(int s, int sm);
    case (s)
      1: return sm ? 4'b0000 : 4'b1100;
      2: return sm ? 4'b0000 : 4'b1001;
      3: return sm ? 4'b0000 : 4'b1010;
      4: return 4'b0100; 5: return 4'b0001; 6: return 4'b0010;
      7: return 4'b0100; 8: return 4'b0001; 9: return 4'b0010;
      default: return 4'b1010;
    endcase
  endfunction

  function automatic int mRdA(int s);
    case (s) 1, 4: return 0; 2, 5: return 1; 3, 6: return 2; default: return 3; endcase
  endfunction

  function automatic int mRdB(int s);
    case (s) 1, 4, 7: return 1; 2, 5, 8: return 2; default: return 0; endcase
  endfunction

  function automatic bit mPre(int s);
    return (s >= 4);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // at the first clock of a model state (cnt = 0), run it to the next state's first clock
  task automatic runState(input bit withhold);
    logic [3:0] mk;
    string rdTag;
    bit isDec;
    int sm;
    mk = mMask(ms, mcs);
    isDec = (ms >= 1 && ms <= 3);
    rdTag = (ms >= 7) ? "R4" : "R3";
    chk(meStart === 1'b1, "R5 start", int'(meStart), 1);
    chk(int'(rdBankA) == mRdA(ms), rdTag, int'(rdBankA), mRdA(ms));
    chk(int'(rdBankB) == mRdB(ms), rdTag, int'(rdBankB), mRdB(ms));
    if (isDec) chk(fillReq == mk, "R2 decision refill", int'(fillReq), int'(mk));
    else       chk(fillReq == mk, (ms >= 7) ? "R4 refill" : "R3 refill", int'(fillReq), int'(mk));
    chk(bankWe == mk, "R6 we", int'(bankWe), int'(mk));
    chk(mk[rdBankA] == 1'b0 && mk[rdBankB] == 1'b0, "R7", int'(mk), 0);
    chk(bank3Sleep == (!mk[3] && mRdA(ms) != 3), "R8", int'(bank3Sleep), int'(!mk[3] && mRdA(ms) != 3));
    chk(int'(winX) == (winMX & 32'hFFF), "R9 x", int'(winX), winMX & 32'hFFF);
    chk(int'(winY) == (winMY & 32'hFFF), "R9 y", int'(winY), winMY & 32'hFFF);
    chk(fillErr == errExp, "R10", int'(fillErr), int'(errExp));
    if (mPre(ms)) begin
      if (vecIdx < NVEC) begin
        curVX = prevMX + (vecIdx % 15) - 7;
        curVY = prevMY + (vecIdx / 15) - 7;
        vecIdx++;
      end else begin
        curVX = prevMX;
        curVY = prevMY;
      end
      mvX = curVX[MVW-1:0];
      mvY = curVY[MVW-1:0];
    end
    for (int k = 1; k <= LEN; k++) begin
      @(negedge clk);
      if (k == 1) chk(meStart === 1'b0, "R5 single", int'(meStart), 0);
      if (k == FILL - 1) chk(bankWe == mk, "R6 we hold", int'(bankWe), int'(mk));
      if (k == FILL) chk(bankWe == 4'b0, "R6 we off", int'(bankWe), 0);
      if (k == FILL + 1) begin
        chk(fillReq == mk, "R6 req hold", int'(fillReq), int'(mk));
        if (!withhold) fillDone = mk;
      end
      if (k == FILL + 2) fillDone = 4'b0;
      if (k == FILL + 3)
        chk(fillReq == (withhold ? mk : 4'b0), "R6 req clear", int'(fillReq), int'(withhold ? mk : 4'b0));
      if (k == LEN - 1) begin
        if (withhold && mk != 4'b0) errExp = 1'b1;
        if (mPre(ms)) begin
          sm = (iabs(curVX - prevMX) < 6 && iabs(curVY - prevMY) < 6) ? 1 : 0;
          if (sm != 0) winMX = winMX + 16;
          else begin winMX = curVX; winMY = curVY; end
          prevMX = curVX;
          prevMY = curVY;
          ms = mNext(ms, 0);
          mcs = sm;
        end else begin
          ms = mNext(ms, mcs);
        end
      end
    end
  endtask

  initial begin : main
    bit armed;
    curVX = 5; curVY = -3;
    mvX = curVX[MVW-1:0]; mvY = curVY[MVW-1:0];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 fill-only phase, cnt = 0
    chk(fillReq == 4'b1010, "R1 req", int'(fillReq), 10);
    chk(bankWe == 4'b1010, "R1 we", int'(bankWe), 10);
    chk(meStart == 1'b0, "R1 no start", int'(meStart), 0);
    chk(fillErr == 1'b0, "R10 reset", int'(fillErr), 0);
    @(negedge clk);
    @(negedge clk);
    fillDone = 4'b1010;
    @(negedge clk);
    fillDone = 4'b0;
    chk(fillReq == 4'b0, "R1 done", int'(fillReq), 0);
    @(negedge clk);
    chk(bankWe == 4'b0, "R1 we off", int'(bankWe), 0);
    chk(meStart == 1'b0, "R1 still init", int'(meStart), 0);
    @(negedge clk);
    chk(meStart == 1'b1, "R1 first start", int'(meStart), 1);
    prevMX = curVX; prevMY = curVY;
    winMX = curVX; winMY = curVY;
    ms = 7; mcs = 0; errExp = 1'b0; vecIdx = 0;
    while (vecIdx < NVEC) runState(1'b0);
    armed = 1'b1;
    while (armed) begin
      if (mMask(ms, mcs) != 4'b0) begin
        runState(1'b1);
        armed = 1'b0;
      end else runState(1'b0);
    end
    runState(1'b0);
    runState(1'b0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule